// File: doc/BRIEF.md
# Buffer Descriptor Ring Engine

This block manages the transmit and receive descriptor rings of an Ethernet controller. The descriptors sit in a small local descriptor store that software fills and reads back through a simple RAM port. Each entry is 64 bits wide, packed as `{status[15:0], length[15:0], pointer[31:0]}`. Status bit 15 is the ownership flag: "empty" on the receive ring, "ready" on the transmit ring. Bit 13 marks the last entry of a ring. Bit 11 marks a complete frame, bit 10 asks for an appended CRC on transmit, and bit 0 flags a bad received frame.

On the receive side, frames arrive as a byte stream. Every byte is counted, including the trailing 4-byte FCS. When the frame ends, the engine writes the final status and length into the current empty descriptor. On the transmit side, the engine walks the ready descriptors and emits one buffer address per byte, from the descriptor pointer up to pointer plus length minus one. It clears ready on each descriptor once that buffer has been sent.

Each side is started by a one-cycle kick pulse and reports an active flag. The active flag drops when the engine finds a descriptor it does not own. Pulling the enable input low idles both sides and returns both ring indices to zero. A ring occupies store slots `base + index`. The slot arithmetic wraps modulo the store depth, which must be a power of two.

Top module: `bdr_engine`

## Requirements
- R1: After reset, rxActive, txActive and txValid are all 0.
- R2: A frame accepted into an empty receive descriptor is written back with the following fields:
  - status bit 15 cleared and status bit 11 set;
  - bit 13 unchanged and the pointer unchanged;
  - the length set to the number of bytes received, the FCS bytes included.
- R3: A frame whose rxBad is high with its last byte is written back with status bit 0 set.
- R4: A frame longer than maxRxLen is written back with length maxRxLen and status bit 0 set. A frame of exactly maxRxLen bytes gets the same length with bit 0 clear.
- R5: After a descriptor with bit 13 set has been used, the ring continues at index 0, which is slot base + 0.
- R6: Receive side, losing and regaining ownership:
  - Once the next receive descriptor lacks bit 15, rxActive falls to 0.
  - Frames arriving in that state leave every descriptor unchanged.
  - A later rxKick resumes reception at the same index.
- R7: For a transmit descriptor with bit 15 set and length L>0, the engine emits exactly L txValid cycles with txAddr = pointer+0 … pointer+L-1 in order. txLast is high on the final byte only, and txCrc equals status bit 10 on that byte and is 0 otherwise.
- R8: After sending, the engine clears status bit 15 of the descriptor and moves to the next one. txActive falls to 0 when the next descriptor lacks bit 15.
- R9: A single transmit descriptor with both bit 13 and bit 15 set is sent exactly once per kick.
- R10: While enable is low, both active flags are 0 and kicks have no effect. Both ring indices return to 0.
- R11: A ready transmit descriptor of length 0 emits no bytes and still has bit 15 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low idles both sides and zeroes ring indices |
| rxKick | input | 1 | Pulse: start or resume receive processing |
| txKick | input | 1 | Pulse: start transmit processing |
| rxBase | input | $clog2(DEPTH) | Receive ring base slot |
| txBase | input | $clog2(DEPTH) | Transmit ring base slot |
| maxRxLen | input | 16 | Maximum receive buffer size in bytes (at least 1) |
| swWe | input | 1 | Descriptor store write strobe |
| swAddr | input | $clog2(DEPTH) | Descriptor store slot for read and write |
| swWdata | input | 64 | Descriptor to write |
| swRdata | output | 64 | Descriptor at swAddr (combinational) |
| rxValid | input | 1 | Receive byte valid |
| rxLast | input | 1 | Last byte of the frame |
| rxBad | input | 1 | Frame error, sampled with the last byte |
| rxActive | output | 1 | Receive processing active |
| txActive | output | 1 | Transmit processing active |
| txValid | output | 1 | Transmit byte valid |
| txAddr | output | 32 | Buffer address of the byte being sent |
| txLast | output | 1 | Final byte of the buffer |
| txCrc | output | 1 | CRC append request, high with txLast |

## Verification
A wrong ring index shows up at the next frame. A received frame lands in a different slot, or a transmit burst starts at another descriptor's pointer. Either is visible at the first readback or the first txAddr. A stale ownership flag shows up as a duplicate burst or as an active flag that stays high after the ring runs dry, within a few cycles of the last writeback. A wrong byte counter shows up in the written length, or in where txLast lands, on the very frame that exercises it.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int STAT_OWN   = 15;
  localparam int STAT_WRAP  = 13;
  localparam int STAT_LAST  = 11;
  localparam int STAT_TXCRC = 10;
  localparam int STAT_ERR   = 0;
  localparam int HW = 16;
  localparam int PW = 32;
  localparam int DW = 2 * HW + PW;

  typedef struct packed {
    logic [HW-1:0] status;
    logic [HW-1:0] len;
    logic [PW-1:0] ptr;
  } desc_t;

  typedef struct packed {
    logic rxByte;
    logic rxFirst;
    logic rxWb;
    logic txLoad;
    logic txStep;
    logic txWb;
    logic idxClr;
  } strobe_t;
endpackage

// File: rtl/bdr_datapath.sv
module bdr_datapath import bdr_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          swWe,
  input  logic [IW-1:0] swAddr,
  input  desc_t         swWdata,
  output desc_t         swRdata,
  input  logic [IW-1:0] rxBase,
  input  logic [IW-1:0] txBase,
  input  logic [HW-1:0] maxRxLen,
  input  logic          rxBad,
  output logic          rxOwned,
  output logic          txOwned,
  output logic          txLenZero,
  output logic          txAtLast,
  output logic          txCrcFlag,
  output logic [PW-1:0] txAddr
);
  desc_t ring [DEPTH];
  logic [IW-1:0] rxIdx, txIdx, rxSlot, txSlot;
  logic [HW-1:0] rxCnt, txCnt, rxLenFinal;
  logic rxTrunc, rxTruncFinal;
  desc_t rxCur, txCur, rxWbDesc, txWbDesc;

  assign rxSlot = rxBase + rxIdx;
  assign txSlot = txBase + txIdx;
  assign rxCur  = ring[rxSlot];
  assign txCur  = ring[txSlot];
  assign swRdata = ring[swAddr];

  always_comb begin
    if (stb.rxFirst) begin
      rxLenFinal = 16'd1;
      rxTruncFinal = 1'b0;
    end else if (rxCnt >= maxRxLen) begin
      rxLenFinal = rxCnt;
      rxTruncFinal = 1'b1;
    end else begin
      rxLenFinal = rxCnt + 16'd1;
      rxTruncFinal = rxTrunc;
    end
    rxWbDesc = rxCur;
    rxWbDesc.status = '0;
    rxWbDesc.status[STAT_WRAP] = rxCur.status[STAT_WRAP];
    rxWbDesc.status[STAT_LAST] = 1'b1;
    rxWbDesc.status[STAT_ERR]  = rxBad | rxTruncFinal;
    rxWbDesc.len = rxLenFinal;
    txWbDesc = txCur;
    txWbDesc.status[STAT_OWN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else begin
      if (swWe) ring[swAddr] <= swWdata;
      if (stb.txWb) ring[txSlot] <= txWbDesc;
      if (stb.rxWb) ring[rxSlot] <= rxWbDesc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIdx <= '0;
      txIdx <= '0;
      rxCnt <= '0;
      rxTrunc <= 1'b0;
      txCnt <= '0;
    end else begin
      if (stb.idxClr) begin
        rxIdx <= '0;
        txIdx <= '0;
      end else begin
        if (stb.rxWb) rxIdx <= rxCur.status[STAT_WRAP] ? '0 : IW'(rxIdx + 1'b1);
        if (stb.txWb) txIdx <= txCur.status[STAT_WRAP] ? '0 : IW'(txIdx + 1'b1);
      end
      if (stb.rxByte) begin
        rxCnt <= rxLenFinal;
        rxTrunc <= rxTruncFinal;
      end
      if (stb.txLoad) txCnt <= '0;
      else if (stb.txStep) txCnt <= txCnt + 16'd1;
    end
  end

  assign rxOwned   = rxCur.status[STAT_OWN];
  assign txOwned   = txCur.status[STAT_OWN];
  assign txLenZero = (txCur.len == '0);
  assign txAtLast  = (txCnt == txCur.len - 16'd1);
  assign txCrcFlag = txCur.status[STAT_TXCRC];
  assign txAddr    = txCur.ptr + {{(PW-HW){1'b0}}, txCnt};

  a_r2_rx_wb_hands_back: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxWb && !swWe) |=> (!ring[$past(rxSlot)].status[STAT_OWN] &&
                              ring[$past(rxSlot)].status[STAT_LAST]));
  a_r4_len_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxWb && !swWe && maxRxLen != '0) |=> ring[$past(rxSlot)].len <= $past(maxRxLen));
  a_r7_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txStep && !txAtLast) |=> txAddr == $past(txAddr) + 32'd1);
  a_r9_ready_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txWb && !swWe && !stb.rxWb) |=> !ring[$past(txSlot)].status[STAT_OWN]);
endmodule

// File: rtl/bdr_control.sv
module bdr_control import bdr_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    rxKick,
  input  logic    txKick,
  input  logic    rxValid,
  input  logic    rxLast,
  input  logic    rxOwned,
  input  logic    txOwned,
  input  logic    txLenZero,
  input  logic    txAtLast,
  output strobe_t stb,
  output logic    rxActive,
  output logic    txActive,
  output logic    txValid,
  output logic    txLast
);
  typedef enum logic [1:0] {RX_OFF, RX_CHK, RX_ON} rxState_e;
  typedef enum logic [1:0] {TX_OFF, TX_CHK, TX_SEND, TX_DONE} txState_e;
  rxState_e rxState, rxNext;
  txState_e txState, txNext;
  logic inFrame, inFrameN, dropping, droppingN, accept;

  always_comb begin
    stb = '0;
    stb.idxClr = !enable;
    rxNext = rxState;
    txNext = txState;
    inFrameN = inFrame;
    droppingN = dropping;
    accept = 1'b0;
    if (rxValid) begin
      accept = enable && (inFrame ? !dropping : (rxState == RX_ON));
      stb.rxByte  = accept;
      stb.rxFirst = accept && !inFrame;
      stb.rxWb    = accept && rxLast;
      inFrameN  = !rxLast;
      droppingN = !accept && !rxLast;
    end
    if (!enable) begin
      rxNext = RX_OFF;
      txNext = TX_OFF;
      if (inFrame) droppingN = inFrameN;
    end else begin
      unique case (rxState)
        RX_OFF: if (rxKick) rxNext = RX_CHK;
        RX_CHK: rxNext = rxOwned ? RX_ON : RX_OFF;
        default: if (stb.rxWb) rxNext = RX_CHK;
      endcase
      unique case (txState)
        TX_OFF: if (txKick) txNext = TX_CHK;
        TX_CHK:
          if (!txOwned) txNext = TX_OFF;
          else if (txLenZero) txNext = TX_DONE;
          else begin
            stb.txLoad = 1'b1;
            txNext = TX_SEND;
          end
        TX_SEND: begin
          stb.txStep = 1'b1;
          if (txAtLast) txNext = TX_DONE;
        end
        default: begin
          stb.txWb = 1'b1;
          txNext = TX_CHK;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_OFF;
      txState <= TX_OFF;
      inFrame <= 1'b0;
      dropping <= 1'b0;
    end else begin
      rxState <= rxNext;
      txState <= txNext;
      inFrame <= inFrameN;
      dropping <= droppingN;
    end
  end

  assign rxActive = (rxState != RX_OFF);
  assign txActive = (txState != TX_OFF);
  assign txValid  = (txState == TX_SEND);
  assign txLast   = txValid && txAtLast;

  a_r10_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!rxActive && !txActive));
  a_r6_no_wb_while_off: assert property (@(posedge clk) disable iff (!rstN)
    (!rxActive && !inFrame) |-> !stb.rxWb);
endmodule

// File: rtl/bdr_engine.sv
module bdr_engine import bdr_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          rxKick,
  input  logic          txKick,
  input  logic [IW-1:0] rxBase,
  input  logic [IW-1:0] txBase,
  input  logic [15:0]   maxRxLen,
  input  logic          swWe,
  input  logic [IW-1:0] swAddr,
  input  logic [63:0]   swWdata,
  output logic [63:0]   swRdata,
  input  logic          rxValid,
  input  logic          rxLast,
  input  logic          rxBad,
  output logic          rxActive,
  output logic          txActive,
  output logic          txValid,
  output logic [31:0]   txAddr,
  output logic          txLast,
  output logic          txCrc
);
  strobe_t stb;
  desc_t swRd;
  logic rxOwned, txOwned, txLenZero, txAtLast, txCrcFlag;

  bdr_control uCtrl (
    .clk, .rstN, .enable, .rxKick, .txKick, .rxValid, .rxLast,
    .rxOwned, .txOwned, .txLenZero, .txAtLast,
    .stb, .rxActive, .txActive, .txValid, .txLast
  );

  bdr_datapath #(.DEPTH(DEPTH)) uData (
    .clk, .rstN, .stb, .swWe, .swAddr, .swWdata(desc_t'(swWdata)), .swRdata(swRd),
    .rxBase, .txBase, .maxRxLen, .rxBad,
    .rxOwned, .txOwned, .txLenZero, .txAtLast, .txCrcFlag, .txAddr
  );

  assign swRdata = swRd;
  assign txCrc = txLast && txCrcFlag;
endmodule

// File: tb/tb_bdr_engine.sv
module tb_bdr_engine;
  logic clk = 0, rstN = 0, enable = 0, rxKick = 0, txKick = 0;
  logic [3:0] rxBase = 0, txBase = 0, swAddr = 0;
  logic [15:0] maxRxLen = 16'd1518;
  logic swWe = 0;
  logic [63:0] swWdata = 0, swRdata;
  logic rxValid = 0, rxLast = 0, rxBad = 0;
  logic rxActive, txActive, txValid, txLast, txCrc;
  logic [31:0] txAddr;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] logAddr [64];
  logic logLast [64];
  logic logCrc [64];
  int logN = 0;

  always #5 clk = ~clk;

  bdr_engine dut (.*);

  always @(negedge clk) if (txValid && logN < 64) begin
    logAddr[logN] = txAddr;
    logLast[logN] = txLast;
    logCrc[logN] = txCrc;
    logN++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrDesc(int slot, logic [15:0] st, logic [15:0] ln, logic [31:0] p);
    @(negedge clk);
    swWe = 1; swAddr = 4'(slot); swWdata = {st, ln, p};
    @(negedge clk);
    swWe = 0;
  endtask

  task automatic rdDesc(int slot, output logic [63:0] d);
    @(negedge clk);
    swAddr = 4'(slot);
    #1 d = swRdata;
  endtask

  task automatic kickRx();
    @(negedge clk); rxKick = 1;
    @(negedge clk); rxKick = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic kickTx();
    @(negedge clk); txKick = 1;
    @(negedge clk); txKick = 0;
    for (int i = 0; i < 300 && txActive; i++) @(negedge clk);
  endtask

  task automatic sendFrame(int n, bit bad);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1; rxLast = (i == n - 1); rxBad = bad && (i == n - 1);
    end
    @(negedge clk);
    rxValid = 0; rxLast = 0; rxBad = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rxActive", rxActive, 0);
    chk("R1 txActive", txActive, 0);
    chk("R1 txValid", txValid, 0);
  endtask

  task automatic t_rx_basic();
    logic [63:0] d;
    wrDesc(0, 16'h8000, 0, 32'd100);
    wrDesc(1, 16'hA000, 0, 32'd200);
    kickRx();
    chk("R6 rxActive after kick", rxActive, 1);
    sendFrame(20, 0);
    rdDesc(0, d);
    chk("R2 writeback", d, {16'h0800, 16'd20, 32'd100});
    chk("R6 still active", rxActive, 1);
  endtask

  task automatic t_rx_err_wrap();
    logic [63:0] d;
    sendFrame(10, 1);
    rdDesc(1, d);
    chk("R3 error flag", d, {16'h2801, 16'd10, 32'd200});
    chk("R6 inactive when next not empty", rxActive, 0);
  endtask

  task automatic t_rx_drop();
    logic [63:0] d;
    sendFrame(30, 0);
    rdDesc(0, d);
    chk("R6 dropped frame desc0", d, {16'h0800, 16'd20, 32'd100});
    rdDesc(1, d);
    chk("R6 dropped frame desc1", d, {16'h2801, 16'd10, 32'd200});
  endtask

  task automatic t_rx_trunc();
    logic [63:0] d;
    maxRxLen = 16;
    wrDesc(0, 16'h8000, 0, 32'd300);
    wrDesc(1, 16'hA000, 0, 32'd400);
    kickRx();
    sendFrame(40, 0);
    rdDesc(0, d);
    chk("R5 R4 truncated into index 0", d, {16'h0801, 16'd16, 32'd300});
    sendFrame(16, 0);
    rdDesc(1, d);
    chk("R4 exact max no error", d, {16'h2800, 16'd16, 32'd400});
    maxRxLen = 16'd1518;
  endtask

  task automatic t_tx_two();
    logic [63:0] d;
    int s;
    txBase = 8;
    wrDesc(8, 16'h8C00, 16'd4, 32'h1000);
    wrDesc(9, 16'hA800, 16'd3, 32'h2000);
    s = logN;
    kickTx();
    chk("R7 byte count", logN - s, 7);
    for (int i = 0; i < 4; i++) chk("R7 addr d0", logAddr[s+i], 32'h1000 + i);
    for (int i = 0; i < 3; i++) chk("R7 addr d1", logAddr[s+4+i], 32'h2000 + i);
    chk("R7 last d0", {logLast[s+2], logLast[s+3]}, 2'b01);
    chk("R7 crc d0", {logCrc[s+2], logCrc[s+3]}, 2'b01);
    chk("R7 last/crc d1", {logLast[s+6], logCrc[s+6]}, 2'b10);
    rdDesc(8, d);
    chk("R8 ready cleared d0", d[63:48], 16'h0C00);
    rdDesc(9, d);
    chk("R8 ready cleared d1", d[63:48], 16'h2800);
    chk("R8 txActive low", txActive, 0);
  endtask

  task automatic t_tx_lone();
    logic [63:0] d;
    int s;
    wrDesc(8, 16'hA800, 16'd2, 32'h3000);
    s = logN;
    kickTx();
    chk("R9 lone sent once", logN - s, 2);
    chk("R9 lone addr", logAddr[s+1], 32'h3001);
    rdDesc(8, d);
    chk("R9 lone ready cleared", d[63:48], 16'h2800);
  endtask

  task automatic t_tx_zero();
    logic [63:0] d;
    int s;
    wrDesc(8, 16'hA000, 16'd0, 32'h3500);
    s = logN;
    kickTx();
    chk("R11 no bytes", logN - s, 0);
    rdDesc(8, d);
    chk("R11 ready cleared", d[63:48], 16'h2000);
  endtask

  task automatic t_enable();
    logic [63:0] d;
    int s;
    wrDesc(8, 16'h8800, 16'd1, 32'h3800);
    wrDesc(9, 16'h2000, 16'd1, 32'h3900);
    kickTx();
    wrDesc(0, 16'h8000, 0, 32'd500);
    wrDesc(1, 16'hA000, 0, 32'd600);
    kickRx();
    sendFrame(6, 0);
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R10 rx idle when disabled", rxActive, 0);
    chk("R10 tx idle when disabled", txActive, 0);
    txKick = 1; rxKick = 1;
    @(negedge clk); txKick = 0; rxKick = 0;
    @(negedge clk);
    chk("R10 kick ignored", {rxActive, txActive}, 2'b00);
    enable = 1;
    wrDesc(8, 16'h8800, 16'd1, 32'h4000);
    wrDesc(9, 16'hA800, 16'd1, 32'h5000);
    s = logN;
    kickTx();
    chk("R10 tx index reset", logAddr[s], 32'h4000);
    wrDesc(0, 16'h8000, 0, 32'd700);
    kickRx();
    sendFrame(5, 0);
    rdDesc(0, d);
    chk("R10 rx index reset", d, {16'h0800, 16'd5, 32'd700});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1; enable = 1;
    repeat (2) @(negedge clk);
    t_rx_basic();
    t_rx_err_wrap();
    t_rx_drop();
    t_rx_trunc();
    t_tx_two();
    t_tx_lone();
    t_tx_zero();
    t_enable();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule